// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a processor core built around a micro-routine store rather than a wide hardwired decoder. A writable lookup table turns each incoming opcode into the start address of a micro-routine. A micro-program counter then walks that routine through an internal control store, one microinstruction per clock. Each microinstruction drives the datapath control bits for its own cycle and names how the next address is formed: step to the following word, jump to a literal address, or end the routine.

Opcodes are offered with a valid/ready handshake and are taken only while the unit waits between routines. Undefined opcodes point at a shared trap routine by default. While that routine runs, an illegal-instruction flag is raised. Because the table can be rewritten while the unit is running, a defined opcode can be sent to the trap, or an undefined one can be given a real routine. A change affects only dispatches that happen after it.

Top module: `mseq_top`

## Requirements
- R1: After reset, op_ready is 1 and busy, done, illegal and ctrl_word are all 0.
- R2: op_ready is 1 only while no routine runs. An opcode is taken on a rising edge where op_valid and op_ready are both 1, and busy is 1 from the following cycle.
- R3: While no routine runs, ctrl_word is 0. While one runs, ctrl_word is the control field of the current word. For defined opcode k (0 to 7), word j of its routine sits at address 8k+j and carries control value (k+1)*256+j.
- R4: Each microword carries a 2-bit mode: 00 steps to the next address and 01 jumps to the word's 8-bit literal. In routines k = 3 to 7, word 1 jumps to word 3, so word 2 is skipped. A routine therefore lasts k+1 cycles for k < 3 and k cycles for k >= 3.
- R5: A word whose mode is 10 (11 behaves the same) ends the routine. done is 1 in that word's cycle, and in the next cycle the unit is back in the waiting state with op_ready 1.
- R6: After reset, opcodes 0 to 7 map to address 8k and opcodes 8 to 31 map to trap address 240. The trap routine is two words, 0xFFF then 0xFFE. illegal is 1 for every cycle of any routine dispatched through a table entry equal to 240, and 0 otherwise.
- R7: When map_we is 1 on an edge, table entry map_idx takes map_addr. A later dispatch of that opcode uses the new address, so a defined opcode can be made to trap and an undefined opcode can be made legal.
- R8: A table write has no effect on a routine already running. When a write and an acceptance of the same opcode happen on the same edge, the dispatch uses the old entry.
- R9: op_valid while a routine runs is ignored. The routine continues unchanged, and no routine starts from that request afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An opcode is offered |
| op_code | input | 5 | Opcode offered |
| op_ready | output | 1 | Unit is waiting for an opcode |
| map_we | input | 1 | Table write enable |
| map_idx | input | 5 | Table entry to write |
| map_addr | input | 8 | Start address to store |
| ctrl_word | output | 12 | Datapath control bits for this cycle |
| busy | output | 1 | A micro-routine is running |
| done | output | 1 | Current word ends the routine |
| illegal | output | 1 | The running routine is the illegal-instruction trap |

## Verification
The jump and step properties assume that table writes only store the start of a routine or the trap address. If an arbitrary address were stored, the counter could enter a region of end-only filler words. The properties would still hold there, but the behaviour being exercised would be meaningless. The stimulus therefore writes only routine bases (8k) or 240. It changes op_valid, op_code and the write port only at falling edges, and holds each request for exactly one cycle, so every input is stable and known at each rising edge.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int OPC_W     = 5;
  localparam int UA_W      = 8;
  localparam int CTRL_W    = 12;
  localparam int DEF_OPS   = 8;     // opcodes that own a routine
  localparam int SLOT      = 8;     // words reserved per routine
  localparam int TRAP_BASE = 240;   // trap routine entry
  localparam int UW_W      = CTRL_W + 2 + UA_W;

  typedef enum logic [1:0] {
    NX_INC = 2'b00,
    NX_JMP = 2'b01,
    NX_END = 2'b10,
    NX_RSV = 2'b11
  } nx_mode_e;

  // table entry loaded at reset
  function automatic logic [UA_W-1:0] map_default(input int op);
    if (op < DEF_OPS) return UA_W'(op * SLOT);
    return UA_W'(TRAP_BASE);
  endfunction

  function automatic logic [UW_W-1:0] pack_uword(input logic [CTRL_W-1:0] c,
                                                 input nx_mode_e m,
                                                 input logic [UA_W-1:0] n);
    return {c, m, n};
  endfunction

  // control store contents, computed per address
  function automatic logic [UW_W-1:0] store_word(input int a);
    int k;
    int j;
    logic [CTRL_W-1:0] c;
    k = a / SLOT;
    j = a % SLOT;
    if (a == TRAP_BASE)     return pack_uword('1, NX_INC, '0);
    if (a == TRAP_BASE + 1) return pack_uword({{(CTRL_W-1){1'b1}}, 1'b0}, NX_END, '0);
    if (k < DEF_OPS && j <= k) begin
      c = CTRL_W'((k + 1) * 256 + j);
      if (j == k)           return pack_uword(c, NX_END, '0);
      if (j == 1 && k >= 3) return pack_uword(c, NX_JMP, UA_W'(a + 2));
      return pack_uword(c, NX_INC, '0);
    end
    return pack_uword('0, NX_END, '0);
  endfunction

  function automatic logic is_end(input nx_mode_e m);
    return m[1];
  endfunction

  function automatic logic [UA_W-1:0] next_upc(input nx_mode_e m,
                                               input logic [UA_W-1:0] pc,
                                               input logic [UA_W-1:0] lit);
    if (m == NX_JMP) return lit;
    return pc + 1'b1;
  endfunction
endpackage

// File: rtl/mseq_map.sv
module mseq_map
  import mseq_pkg::*;
#(
  parameter int IDX_W  = OPC_W,
  parameter int ADDR_W = UA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_data
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ADDR_W-1:0] tbl_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= ADDR_W'(map_default(i));
    end else if (wr_en) begin
      tbl_q[wr_idx] <= wr_data;
    end
  end

  // read sees the value before any write on the same edge
  assign rd_data = tbl_q[rd_idx];
endmodule

// File: rtl/mseq_store.sv
module mseq_store
  import mseq_pkg::*;
#(
  parameter int ADDR_W = UA_W,
  parameter int WORD_W = UW_W
) (
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    assign rom[a] = WORD_W'(store_word(a));
  end

  assign rd_word = rom[rd_addr];
endmodule

// File: rtl/mseq_seq.sv
module mseq_seq
  import mseq_pkg::*;
#(
  parameter int ADDR_W = UA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [ADDR_W-1:0] map_entry,
  input  nx_mode_e          cur_mode,
  input  logic [ADDR_W-1:0] cur_next,
  output logic              op_ready,
  output logic              running,
  output logic              accept,
  output logic              finish,
  output logic              trap_run,
  output logic [ADDR_W-1:0] upc
);
  typedef enum logic {ST_DISP, ST_RUN} st_e;

  st_e               st_q;
  logic [ADDR_W-1:0] upc_q;
  logic              trap_q;

  assign running  = (st_q == ST_RUN);
  assign op_ready = (st_q == ST_DISP);
  assign accept   = op_valid && op_ready;
  assign finish   = running && is_end(cur_mode);
  assign trap_run = running && trap_q;
  assign upc      = upc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_DISP;
      upc_q  <= '0;
      trap_q <= 1'b0;
    end else begin
      case (st_q)
        ST_DISP: begin
          if (accept) begin
            st_q   <= ST_RUN;
            upc_q  <= map_entry;
            trap_q <= (map_entry == ADDR_W'(TRAP_BASE));
          end
        end
        default: begin
          if (finish) begin
            st_q   <= ST_DISP;
            trap_q <= 1'b0;
          end else begin
            upc_q <= next_upc(cur_mode, upc_q, cur_next);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
#(
  parameter int OP_BITS   = OPC_W,
  parameter int ADDR_BITS = UA_W,
  parameter int CTRL_BITS = CTRL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [OP_BITS-1:0]   op_code,
  output logic                 op_ready,
  input  logic                 map_we,
  input  logic [OP_BITS-1:0]   map_idx,
  input  logic [ADDR_BITS-1:0] map_addr,
  output logic [CTRL_BITS-1:0] ctrl_word,
  output logic                 busy,
  output logic                 done,
  output logic                 illegal
);
  localparam int WORD_BITS = CTRL_BITS + 2 + ADDR_BITS;

  logic [ADDR_BITS-1:0] map_entry;
  logic [ADDR_BITS-1:0] upc;
  logic [WORD_BITS-1:0] cur_word;
  logic [CTRL_BITS-1:0] cur_ctrl;
  nx_mode_e             cur_mode;
  logic [ADDR_BITS-1:0] cur_next;
  logic                 running;
  logic                 accept;
  logic                 finish;
  logic                 trap_run;

  mseq_map #(.IDX_W(OP_BITS), .ADDR_W(ADDR_BITS)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (map_we),
    .wr_idx  (map_idx),
    .wr_data (map_addr),
    .rd_idx  (op_code),
    .rd_data (map_entry)
  );

  mseq_store #(.ADDR_W(ADDR_BITS), .WORD_W(WORD_BITS)) u_store (
    .rd_addr (upc),
    .rd_word (cur_word)
  );

  assign cur_ctrl = cur_word[WORD_BITS-1 -: CTRL_BITS];
  assign cur_mode = nx_mode_e'(cur_word[ADDR_BITS+1 -: 2]);
  assign cur_next = cur_word[ADDR_BITS-1:0];

  mseq_seq #(.ADDR_W(ADDR_BITS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .map_entry (map_entry),
    .cur_mode  (cur_mode),
    .cur_next  (cur_next),
    .op_ready  (op_ready),
    .running   (running),
    .accept    (accept),
    .finish    (finish),
    .trap_run  (trap_run),
    .upc       (upc)
  );

  assign ctrl_word = running ? cur_ctrl : '0;
  assign busy      = running;
  assign done      = finish;
  assign illegal   = trap_run;
endmodule

// File: rtl/mseq_checker.sv
module mseq_checker #(
  parameter int ADDR_BITS = 8,
  parameter int CTRL_BITS = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 op_valid,
  input logic                 op_ready,
  input logic                 busy,
  input logic                 done,
  input logic                 illegal,
  input logic [CTRL_BITS-1:0] ctrl_word,
  input logic [1:0]           cur_mode,
  input logic [ADDR_BITS-1:0] cur_next,
  input logic [ADDR_BITS-1:0] upc
);
  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> !busy);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> busy);

  assert_idle_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ctrl_word == '0));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_mode == 2'b00) |=> (upc == ADDR_BITS'($past(upc) + 1'b1)));

  assert_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_mode == 2'b01) |=> (upc == $past(cur_next)));

  assert_end_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> op_ready);

  assert_done_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_illegal_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> busy);

  assert_keep_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

bind mseq_top mseq_checker #(.ADDR_BITS(ADDR_BITS), .CTRL_BITS(CTRL_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_ready  (op_ready),
  .busy      (busy),
  .done      (done),
  .illegal   (illegal),
  .ctrl_word (ctrl_word),
  .cur_mode  (cur_mode),
  .cur_next  (cur_next),
  .upc       (upc)
);

// File: tb/mseq_top_test.sv
`timescale 1ns/1ps
module mseq_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic        op_ready;
  logic        map_we = 1'b0;
  logic [4:0]  map_idx = '0;
  logic [7:0]  map_addr = '0;
  logic [11:0] ctrl_word;
  logic        busy;
  logic        done;
  logic        illegal;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  mseq_top uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_ready(op_ready), .map_we(map_we), .map_idx(map_idx), .map_addr(map_addr),
    .ctrl_word(ctrl_word), .busy(busy), .done(done), .illegal(illegal)
  );

  // {opcode[5], routine[4] (8 = trap), cycles[5], illegal[1]}
  localparam logic [14:0] VECS [10] = '{
    {5'd0,  4'd0, 5'd1, 1'b0},
    {5'd1,  4'd1, 5'd2, 1'b0},
    {5'd2,  4'd2, 5'd3, 1'b0},
    {5'd3,  4'd3, 5'd3, 1'b0},
    {5'd4,  4'd4, 5'd4, 1'b0},
    {5'd5,  4'd5, 5'd5, 1'b0},
    {5'd7,  4'd7, 5'd7, 1'b0},
    {5'd8,  4'd8, 5'd2, 1'b1},
    {5'd20, 4'd8, 5'd2, 1'b1},
    {5'd31, 4'd8, 5'd2, 1'b1}
  };

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // expected control value of step position j in a routine (R3, R6)
  function automatic logic [11:0] exp_ctrl(input int routine, input int j);
    if (routine == 8) return (j == 0) ? 12'hFFF : 12'hFFE;
    return 12'((routine + 1) * 256 + j);
  endfunction

  task automatic map_write(input logic [4:0] idx, input logic [7:0] data);
    map_we = 1'b1; map_idx = idx; map_addr = data;
    @(negedge clk);
    map_we = 1'b0;
  endtask

  // offer one opcode and follow its routine; wr_when: -1 none, 0 with acceptance, n>0 during run
  task automatic run_op(input logic [4:0] op, input int routine, input int exp_cyc,
                        input bit exp_ill, input int wr_when, input logic [4:0] wi,
                        input logic [7:0] wd, input bit poke, input string tag);
    int n;
    int j;
    bit seq_ok;
    bit ill_ok;
    bit rdy_ok;
    int bad_act;
    int bad_exp;
    n = 0; j = 0; seq_ok = 1; ill_ok = 1; rdy_ok = 1; bad_act = 0; bad_exp = 0;
    check(op_ready === 1'b1, {tag, " R2 ready before offer"}, int'(op_ready), 1);
    op_valid = 1'b1; op_code = op;
    if (wr_when == 0) begin map_we = 1'b1; map_idx = wi; map_addr = wd; end
    @(negedge clk);
    op_valid = 1'b0; map_we = 1'b0;
    while (n < 40) begin
      if (seq_ok && (ctrl_word !== exp_ctrl(routine, j) || busy !== 1'b1)) begin
        seq_ok = 0; bad_act = int'(ctrl_word); bad_exp = int'(exp_ctrl(routine, j));
      end
      if (illegal !== exp_ill) ill_ok = 0;
      if (op_ready !== 1'b0) rdy_ok = 0;
      n++;
      if (wr_when == n) begin map_we = 1'b1; map_idx = wi; map_addr = wd; end
      if (poke && n == 1) begin op_valid = 1'b1; op_code = 5'd0; end
      if (done === 1'b1) break;
      j = (j == 1 && routine >= 3 && routine < 8) ? 3 : j + 1;
      @(negedge clk);
      map_we = 1'b0; op_valid = 1'b0;
    end
    map_we = 1'b0; op_valid = 1'b0;
    check(seq_ok, {tag, " R3/R4 control word sequence"}, bad_act, bad_exp);
    check(n == exp_cyc, {tag, " R4/R5 routine length"}, n, exp_cyc);
    check(ill_ok, {tag, " R6 illegal flag"}, int'(illegal), int'(exp_ill));
    check(rdy_ok, {tag, " R2 ready low while running"}, int'(op_ready), 0);
    @(negedge clk);
    check(op_ready === 1'b1 && busy === 1'b0 && ctrl_word === 12'h000,
          {tag, " R5 back to waiting"}, int'({op_ready, busy}), 2);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog R5: actual 100000 cycles expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(op_ready === 1'b1, "R1 ready after reset", int'(op_ready), 1);
    check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
    check(done === 1'b0, "R1 done after reset", int'(done), 0);
    check(illegal === 1'b0, "R1 illegal after reset", int'(illegal), 0);
    check(ctrl_word === 12'h000, "R1 control word after reset", int'(ctrl_word), 0);

    // R3 R4 R5 R6: default table walk
    for (int v = 0; v < 10; v++) begin
      run_op(VECS[v][14:10], int'(VECS[v][9:6]), int'(VECS[v][5:1]), VECS[v][0],
             -1, 5'd0, 8'd0, 1'b0, $sformatf("vec%0d", v));
    end

    // R9: request while busy is ignored
    run_op(5'd4, 4, 4, 1'b0, -1, 5'd0, 8'd0, 1'b1, "r9_poke");
    @(negedge clk);
    check(busy === 1'b0, "R9 ignored request starts nothing", int'(busy), 0);

    // R7: defined opcode redirected to the trap
    map_write(5'd3, 8'd240);
    run_op(5'd3, 8, 2, 1'b1, -1, 5'd0, 8'd0, 1'b0, "r7_trap");
    // R7: undefined opcode given routine 5
    map_write(5'd9, 8'd40);
    run_op(5'd9, 5, 5, 1'b0, -1, 5'd0, 8'd0, 1'b0, "r7_legal");

    // R8: write during a run leaves that run alone, then applies
    run_op(5'd6, 6, 6, 1'b0, 2, 5'd6, 8'd240, 1'b0, "r8_midrun");
    run_op(5'd6, 8, 2, 1'b1, -1, 5'd0, 8'd0, 1'b0, "r8_after_mid");

    // R8: write on the acceptance edge uses the old entry
    run_op(5'd2, 2, 3, 1'b0, 0, 5'd2, 8'd240, 1'b0, "r8_same_edge");
    run_op(5'd2, 8, 2, 1'b1, -1, 5'd0, 8'd0, 1'b0, "r8_after_same");

    // R1: reset restores the default table
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(5'd3, 3, 3, 1'b0, -1, 5'd0, 8'd0, 1'b0, "r1_table_reset");

    finish_run();
  end
endmodule